// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the storage and arithmetic side of a processor whose internal transfers all travel over one shared word-wide bus. It holds four general-purpose registers, a program counter, an instruction register, a scratch register, and the two hidden staging registers that sit around the ALU. An external sequencer drives the block each cycle with load enables, drive enables and ALU controls. A memory interface can place a word on the bus, and it can also read the bus.

An arithmetic step takes three bus cycles. First, an operand is moved into the hidden operand register. Second, a second operand is placed on the bus while the ALU result is captured into the hidden result register. Third, that result is driven back onto the bus into its destination. The ALU's first input is either the hidden operand register or the constant four, which is used to step the program counter. The instruction register is also brought out continuously for an external decoder. Sequencing and memory handshaking belong to the surrounding logic.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all nine registers (R0–R3, PC, IR, TEMP, the operand register and the result register) are cleared to 0 at that edge.
- R2: `bus_o` equals the value of the single source whose `drv_en` bit is set. The bit indices are 0–3 for R0–R3, 4 for PC, 5 for IR, 6 for TEMP, 7 for the result register and 8 for `ext_data`. With no bit set, `bus_o` is 0.
- R3: At a rising edge, a register whose `ld_en` bit is set takes the bus value. The bit indices are 0–3 for R0–R3, 4 for PC, 5 for IR, 6 for TEMP and 7 for the operand register. A register whose bit is clear keeps its value.
- R4: `ld_en[8]` loads the result register from the ALU output and never from the bus. The operand register has no drive enable and is seen only through the ALU.
- R5: With `sel_four` = 1, ALU input A is the constant 4. With `sel_four` = 0, ALU input A is the operand register.
- R6: With `alu_op` = 00, the ALU produces A + B + `carry_in`, modulo 2^32. Input B is always the bus.
- R7: With `alu_op` = 01, the ALU produces A − B modulo 2^32, and `carry_in` has no effect.
- R8: With `alu_op` = 10 or 11, the ALU produces A XOR B, and `carry_in` has no effect.
- R9: `ir_o` always shows the instruction register, and it is updated in the cycle after an IR load.
- R10: The sequencer never sets more than one `drv_en` bit in a cycle. When two sources are enabled, the bus carries their bitwise OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 9 | Per-register load enables (index map in R3/R4) |
| drv_en | input | 9 | Per-source bus drive enables (index map in R2) |
| ext_data | input | 32 | Word placed on the bus by the memory interface |
| sel_four | input | 1 | ALU input A select: 1 = constant 4, 0 = operand register |
| alu_op | input | 2 | 00 add, 01 subtract, 1x exclusive-or |
| carry_in | input | 1 | Carry into the adder for the add operation |
| bus_o | output | 32 | Shared internal bus |
| ir_o | output | 32 | Instruction register contents for the decoder |

## Verification
The ALU path is driven with operand pairs chosen to separate the operations and their edge cases. A small add tells addition apart from exclusive-or. An all-ones plus one shows wrap-around. An add with carry set shows that the carry is honoured. Subtractions with the carry set show that the carry is ignored, and a zero minus one shows that the borrow wraps. Two further pairs select the constant four, so input A can only come from the constant and not from the stale operand register.

Transfers between registers go over the bus, and distinct values are loaded into every register. Each register is then read back one at a time, which exposes a swapped enable index. Idle cycles, loads with the enable clear, and a reset in the middle of a run show which registers hold their values and which are cleared.

// File: rtl/sbus_pkg.sv
// Shared constants for the single-bus datapath: word width, the index maps
// of the load and drive enable vectors, and the ALU operation encoding.
package sbus_pkg;
    localparam int WORD_W  = 32;
    localparam int NUM_LD  = 9;
    localparam int NUM_DRV = 9;

    // load-enable indices
    localparam int LD_R0   = 0;
    localparam int LD_PC   = 4;
    localparam int LD_IR   = 5;
    localparam int LD_TEMP = 6;
    localparam int LD_Y    = 7;
    localparam int LD_Z    = 8;

    // drive-enable indices
    localparam int DRV_Z   = 7;
    localparam int DRV_EXT = 8;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_XOR  = 2'b10,
        ALU_XORB = 2'b11
    } alu_op_e;
endpackage

// File: rtl/sbus_reg.sv
// One datapath register with a load enable and a synchronous active-low
// clear. Assumes d is stable before the rising edge.
module sbus_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // capture d on load, clear on reset, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R1
    reg_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);
    // R3
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(d));
    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/sbus_bus.sv
// Shared internal bus built as an AND-OR selector over N sources.
// Assumes at most one drive enable is set; with none set the bus is 0.
module sbus_bus #(
    parameter int W = 32,
    parameter int N = 9
) (
    input  logic [N-1:0]        drv,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);
    // OR together every enabled source
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            if (drv[i]) bus = bus | src[i];
        end
    end
endmodule

// File: rtl/sbus_alu.sv
// Storage-free ALU. Input A is the constant 4 or the operand register;
// input B is the bus. Subtraction reuses the adder with B inverted and a
// forced carry of one.
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         sel_four,
    input  logic [W-1:0] y_val,
    input  logic [W-1:0] b_val,
    input  logic [1:0]   op,
    input  logic         cin,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] FOUR = W'(4);

    logic [W-1:0] a_val;
    logic [W-1:0] b_add;
    logic         c_add;
    logic [W-1:0] sum;

    // pick input A
    always_comb a_val = sel_four ? FOUR : y_val;

    // shared adder operands: invert B and force carry for subtraction
    always_comb begin
        if (alu_op_e'(op) == ALU_SUB) begin
            b_add = ~b_val;
            c_add = 1'b1;
        end else begin
            b_add = b_val;
            c_add = cin;
        end
    end

    // single adder
    always_comb sum = a_val + b_add + {{(W-1){1'b0}}, c_add};

    // result select
    always_comb begin
        case (alu_op_e'(op))
            ALU_ADD, ALU_SUB: res = sum;
            default:          res = a_val ^ b_val;
        endcase
    end
endmodule

// File: rtl/sbus_datapath.sv
// Single-bus datapath top: nine registers, the shared bus and the ALU.
// Assumes the sequencer sets at most one drive enable per cycle.
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [8:0]     ld_en,
    input  logic [8:0]     drv_en,
    input  logic [W-1:0]   ext_data,
    input  logic           sel_four,
    input  logic [1:0]     alu_op,
    input  logic           carry_in,
    output logic [W-1:0]   bus_o,
    output logic [W-1:0]   ir_o
);
    localparam logic [W-1:0] FOUR = W'(4);

    logic [NUM_LD-1:0][W-1:0]  rq;
    logic [NUM_DRV-1:0][W-1:0] src;
    logic [W-1:0]              alu_res;

    // registers: the result register takes the ALU, all others the bus
    for (genvar g = 0; g < NUM_LD; g++) begin : g_reg
        logic [W-1:0] d_sel;
        if (g == LD_Z) begin : g_from_alu
            always_comb d_sel = alu_res;
        end else begin : g_from_bus
            always_comb d_sel = bus_o;
        end
        sbus_reg #(.W(W)) reg_i (
            .clk(clk), .rst_n(rst_n), .ld(ld_en[g]), .d(d_sel), .q(rq[g])
        );
    end

    // bus sources: R0..TEMP, result register, external word
    always_comb begin
        for (int i = 0; i < LD_Y; i++) src[i] = rq[i];
        src[DRV_Z]   = rq[LD_Z];
        src[DRV_EXT] = ext_data;
    end

    sbus_bus #(.W(W), .N(NUM_DRV)) bus_i (
        .drv(drv_en), .src(src), .bus(bus_o)
    );

    sbus_alu #(.W(W)) alu_i (
        .sel_four(sel_four), .y_val(rq[LD_Y]), .b_val(bus_o),
        .op(alu_op), .cin(carry_in), .res(alu_res)
    );

    // decoder view of the instruction register
    always_comb ir_o = rq[LD_IR];

    // R10
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));
    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en == '0 |-> bus_o == '0);
    // R7
    z_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en[LD_Z] && alu_op == 2'b01) |=>
        rq[LD_Z] == ($past(sel_four) ? FOUR : $past(rq[LD_Y])) - $past(bus_o));
    // R9
    ir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en[LD_IR] |=> ir_o == $past(bus_o));
endmodule

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  ld_en;
    logic [8:0]  drv_en;
    logic [31:0] ext_data;
    logic        sel_four;
    logic [1:0]  alu_op;
    logic        carry_in;
    logic [31:0] bus_o;
    logic [31:0] ir_o;

    int checks = 0;
    int errors = 0;
    int conflicts = 0;

    always #5 clk = ~clk;

    sbus_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .drv_en(drv_en),
        .ext_data(ext_data), .sel_four(sel_four), .alu_op(alu_op),
        .carry_in(carry_in), .bus_o(bus_o), .ir_o(ir_o)
    );

    // fields: a[99:68] b[67:36] sel[35] op[34:33] cin[32] exp[31:0]
    localparam logic [99:0] VECS [10] = '{
        {32'h0000_0005, 32'h0000_0007, 1'b0, 2'b00, 1'b0, 32'h0000_000C},
        {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'b00, 1'b0, 32'h0000_0000},
        {32'h0000_000A, 32'h0000_0014, 1'b0, 2'b00, 1'b1, 32'h0000_001F},
        {32'h0000_0064, 32'h0000_0001, 1'b0, 2'b01, 1'b0, 32'h0000_0063},
        {32'h0000_0000, 32'h0000_0001, 1'b0, 2'b01, 1'b0, 32'hFFFF_FFFF},
        {32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 2'b10, 1'b0, 32'h0FF0_0FF0},
        {32'hDEAD_BEEF, 32'h0000_0100, 1'b1, 2'b00, 1'b0, 32'h0000_0104},
        {32'hDEAD_BEEF, 32'h0000_0008, 1'b1, 2'b01, 1'b0, 32'hFFFF_FFFC},
        {32'h0000_000A, 32'h0000_0003, 1'b0, 2'b01, 1'b1, 32'h0000_0007},
        {32'h1234_5678, 32'hFFFF_FFFF, 1'b0, 2'b11, 1'b1, 32'hEDCB_A987}
    };

    // count cycles with more than one drive enable (R10)
    always @(posedge clk) if ($countones(drv_en) > 1) conflicts++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // apply one cycle of controls at the falling edge
    task automatic cyc(input logic [8:0] ld, input logic [8:0] drv,
                       input logic [31:0] ext, input logic sel,
                       input logic [1:0] op, input logic cin);
        @(negedge clk);
        ld_en = ld; drv_en = drv; ext_data = ext;
        sel_four = sel; alu_op = op; carry_in = cin;
    endtask

    // drive one source onto the bus and read it
    task automatic peek(input int idx, output logic [31:0] val);
        cyc(9'd0, 9'(1 << idx), 32'h0, 1'b0, 2'b00, 1'b0);
        #1 val = bus_o;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; ld_en = '0; drv_en = '0; ext_data = '0;
        sel_four = 1'b0; alu_op = 2'b00; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state of every bus-visible register
        for (int i = 0; i < 8; i++) begin
            peek(i, v);
            chk($sformatf("R1 reset src %0d", i), v, 32'h0);
        end
        chk("R9 ir after reset", ir_o, 32'h0);
        // R2 idle bus
        cyc(9'd0, 9'd0, 32'hFFFF_FFFF, 1'b0, 2'b00, 1'b0);
        #1 chk("R2 idle bus", bus_o, 32'h0);
        // R5 operand register cleared: Z = Y + 0
        cyc(9'h100, 9'd0, 32'h0, 1'b0, 2'b00, 1'b0);
        peek(7, v);
        chk("R1 operand reg cleared", v, 32'h0);

        // ALU vector table: R5 R6 R7 R8
        for (int k = 0; k < 10; k++) begin
            logic [99:0] t;
            string tag;
            t = VECS[k];
            tag = t[35] ? "R5" : (t[34:33] == 2'b00) ? "R6" :
                  (t[34:33] == 2'b01) ? "R7" : "R8";
            cyc(9'h080, 9'h100, t[99:68], 1'b0, 2'b00, 1'b0);
            cyc(9'h100, 9'h100, t[67:36], t[35], t[34:33], t[32]);
            peek(7, v);
            chk($sformatf("%s vector %0d", tag, k), v, t[31:0]);
        end

        // R4 result register takes ALU output, not the bus
        cyc(9'h080, 9'h100, 32'h11, 1'b0, 2'b00, 1'b0);
        cyc(9'h100, 9'h100, 32'h22, 1'b0, 2'b00, 1'b0);
        peek(7, v);
        chk("R4 result from alu", v, 32'h33);

        // R3 distinct loads into R0..TEMP, read each back
        for (int i = 0; i < 7; i++)
            cyc(9'(1 << i), 9'h100, 32'h100 + 32'(i) * 32'h1_1111, 1'b0, 2'b00, 1'b0);
        for (int i = 0; i < 7; i++) begin
            peek(i, v);
            chk($sformatf("R3 load reg %0d", i), v, 32'h100 + 32'(i) * 32'h1_1111);
        end
        chk("R9 ir shows loaded value", ir_o, 32'h100 + 32'd5 * 32'h1_1111);

        // R3 register-to-register transfer R1 -> R3
        cyc(9'h008, 9'h002, 32'h0, 1'b0, 2'b00, 1'b0);
        peek(3, v);
        chk("R3 transfer R1 to R3", v, 32'h100 + 32'h1_1111);

        // R3 hold with load clear while the bus carries other data
        cyc(9'd0, 9'h100, 32'h9999_9999, 1'b0, 2'b00, 1'b0);
        cyc(9'd0, 9'h100, 32'h7777_7777, 1'b0, 2'b00, 1'b0);
        peek(2, v);
        chk("R3 hold R2", v, 32'h100 + 32'd2 * 32'h1_1111);

        // R9 IR load and hold across other loads
        cyc(9'h020, 9'h100, 32'hCAFE_F00D, 1'b0, 2'b00, 1'b0);
        cyc(9'h001, 9'h100, 32'h1, 1'b0, 2'b00, 1'b0);
        #1 chk("R9 ir load", ir_o, 32'hCAFE_F00D);

        // R5 PC increment: Z = 4 + PC, then PC <- Z
        cyc(9'h010, 9'h100, 32'h0000_1000, 1'b0, 2'b00, 1'b0);
        cyc(9'h100, 9'h010, 32'h0, 1'b1, 2'b00, 1'b0);
        cyc(9'h010, 9'h080, 32'h0, 1'b0, 2'b00, 1'b0);
        peek(4, v);
        chk("R5 pc step by four", v, 32'h0000_1004);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0; ld_en = '0; drv_en = '0;
        @(negedge clk); rst_n = 1'b1;
        peek(1, v);
        chk("R1 mid-run clear R1", v, 32'h0);
        peek(6, v);
        chk("R1 mid-run clear TEMP", v, 32'h0);
        chk("R1 mid-run clear IR", ir_o, 32'h0);

        // R10 bench never enabled two sources at once
        @(negedge clk);
        chk("R10 drive conflicts", 32'(conflicts), 32'h0);
        finish_run();
    end
endmodule